// File: doc/BRIEF.md
# Fuse Array Word Read Controller

This block fetches words from a one-time-programmable fuse store on behalf of software. The store holds 512 bytes and is modelled as fixed contents with a fixed access time. A word is 1 byte or 4 bytes, chosen by a parameter, and the fuse address counts in words of that size. Software uses a small set of 32-bit registers. It writes the wanted address and then latches it with a separate strobe bit that goes high and then low. It launches the fetch with a start bit that also goes high and then low. It polls a busy flag and finally reads the result from a data register.

The block has a power-down control, which resets to powered down and blocks every fetch while it is set, and a stored encryption-enable flag. The control bits for the programming path are plain storage only. Its status flag always reads as zero. Bus reads are combinational. Writes take effect at the clock edge where select and write-enable are both high.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After reset the control word (offset 0x04) reads 0x0800_0000, with only power-down (bit 27) set. The config word (offset 0x10) reads 0x0000_0400, with encrypt-enable (bit 10) set. The data word (offset 0x08) reads 0.
- R2: The control word stores these writable fields: power-down bit 27, start bit 25, read-enable bit 24, program byte bits 23:16, program-start bit 13, program-enable bit 12, address strobe bit 11 and fuse address bits 10:0. The config word stores only bit 10. Every other offset reads 0.
- R3: The fuse address used by a fetch changes only on a control write that takes the address strobe from 1 to 0. That write's address field is the one latched. Writing the address field alone has no effect on the fetch.
- R4: A fetch is launched by a control write that takes the start bit from 1 to 0 while that same write has read-enable set to 1 and power-down set to 0. Busy (bit 26) reads 1 from the cycle after that write.
- R5: Busy stays 1 for exactly FETCH_CYCLES cycles. The data word is loaded on the same edge that clears busy and does not change at any other time.
- R6: A start pulse written with power-down at 1 or read-enable at 0 is ignored. Busy stays 0 and the data word keeps its value.
- R7: A start pulse during a fetch is ignored. The running fetch completes at its original time with its original address.
- R8: With WORD_BYTES=4, word index i returns fuse bytes 4i to 4i+3 packed little-endian, with byte 4i in bits 7:0.
- R9: With WORD_BYTES=1, word index i returns fuse byte i in bits 7:0, and bits 31:8 are zero.
- R10: A word index whose bytes fall outside the 512-byte store returns 0. That is an index of 128 or more with 4-byte words, or 512 or more with 1-byte words.
- R11: Writes to the busy bits (bits 26 and 14) and writes to the data word are ignored. Bit 14 always reads 0.
- R12: Fuse byte a (0 to 511) holds ((a mod 256) × 13 + 7) mod 256, XORed with 0xFF when a ≥ 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | REG_AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data (0 when not a read) |

## Verification
The bench counts busy cycles after each launch. A launch one cycle late, or a busy flag that does not yet read 1 on the first poll, shows up as a wrong count. Word lookups run through 4-byte and 1-byte instances side by side across the store's edges (indices 127, 128, 511 and 2047). A wrong byte order, missing zero extension or a missing range check gives a wrong data word. Directed cases send start pulses with power-down set, with read-enable clear and during a fetch, and change the address field without a strobe. A design that obeys any of these would fetch from the wrong address or alter the data word. Writes to the busy bits and to the data word are read back to show they left no trace.

// File: rtl/fuse_rd_pkg.sv
`timescale 1ns/1ps
package fuse_rd_pkg;

    localparam int DATA_W  = 32;
    localparam int FADDR_W = 11;

    // register byte offsets
    localparam int OFS_CTRL = 'h04;
    localparam int OFS_DATA = 'h08;
    localparam int OFS_CFG  = 'h10;

    // encrypt-enable position in the config word
    localparam int ENC_POS = 10;

    // control word layout, msb first
    typedef struct packed {
        logic [3:0]         rsvd_hi;
        logic               pwr_down;
        logic               rd_busy;
        logic               rd_go;
        logic               rd_arm;
        logic [7:0]         wr_byte;
        logic               rsvd_mid;
        logic               wr_busy;
        logic               wr_go;
        logic               wr_arm;
        logic               addr_stb;
        logic [FADDR_W-1:0] faddr;
    } ctl_word_t;

    localparam ctl_word_t CTL_RESET = '{pwr_down: 1'b1, default: '0};

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_FETCH = 1'b1
    } seq_state_e;

    // stored copy of a written control word: status and reserved bits dropped
    function automatic ctl_word_t ctl_sanitize(input ctl_word_t c);
        ctl_word_t r;
        r          = c;
        r.rsvd_hi  = '0;
        r.rsvd_mid = 1'b0;
        r.rd_busy  = 1'b0;
        r.wr_busy  = 1'b0;
        return r;
    endfunction

    // fixed fuse contents
    function automatic logic [7:0] fuse_byte(input logic [8:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd13 + 8'd7;
        return t ^ {8{a[8]}};
    endfunction

endpackage

// File: rtl/fuse_array.sv
`timescale 1ns/1ps
module fuse_array
    import fuse_rd_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    parameter int FUSE_BYTES = 512
) (
    input  logic [FADDR_W-1:0] word_idx,
    output logic [DATA_W-1:0]  word
);
    localparam int BA_W      = $clog2(FUSE_BYTES);
    localparam int IDX_LIMIT = FUSE_BYTES / WORD_BYTES;
    localparam int LANES     = DATA_W / 8;

    logic [7:0] rom [FUSE_BYTES];
    logic       in_range;

    for (genvar g = 0; g < FUSE_BYTES; g++) begin : g_rom
        assign rom[g] = fuse_byte(9'(g));
    end

    assign in_range = (int'(word_idx) < IDX_LIMIT);

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        if (b < WORD_BYTES) begin : g_on
            logic [BA_W-1:0] ba;
            assign ba = BA_W'({2'b00, word_idx} * 13'(WORD_BYTES) + 13'(b));
            assign word[8*b +: 8] = in_range ? rom[ba] : 8'h00;
        end else begin : g_off
            assign word[8*b +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/fuse_rd_seq.sv
`timescale 1ns/1ps
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int WORD_BYTES   = 4,
    parameter int FETCH_CYCLES = 16,
    parameter int FUSE_BYTES   = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic [FADDR_W-1:0] addr_lat,
    output logic               busy,
    output logic               launch,
    output logic [DATA_W-1:0]  data_q,
    output logic [FADDR_W-1:0] fetch_addr
);
    localparam int CNT_W = (FETCH_CYCLES > 1) ? $clog2(FETCH_CYCLES) : 1;

    seq_state_e         state_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DATA_W-1:0]  word_now;

    fuse_array #(
        .WORD_BYTES (WORD_BYTES),
        .FUSE_BYTES (FUSE_BYTES)
    ) array_i (
        .word_idx (fetch_addr),
        .word     (word_now)
    );

    assign busy   = (state_q == SEQ_FETCH);
    assign launch = start_req && (state_q == SEQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            cnt_q      <= '0;
            data_q     <= '0;
            fetch_addr <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (launch) begin
                        state_q    <= SEQ_FETCH;
                        cnt_q      <= CNT_W'(FETCH_CYCLES - 1);
                        fetch_addr <= addr_lat;
                    end
                end
                SEQ_FETCH: begin
                    if (cnt_q == '0) begin
                        state_q <= SEQ_IDLE;
                        data_q  <= word_now;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fuse_rd_regs.sv
`timescale 1ns/1ps
module fuse_rd_regs
    import fuse_rd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [REG_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               rd_busy,
    input  logic [DATA_W-1:0]  rd_word,
    output ctl_word_t          ctl_q,
    output logic               enc_q,
    output logic [FADDR_W-1:0] addr_lat,
    output logic               start_req,
    output logic [DATA_W-1:0]  bus_rdata
);
    localparam logic [REG_AW-1:0] A_CTRL = REG_AW'(OFS_CTRL);
    localparam logic [REG_AW-1:0] A_DATA = REG_AW'(OFS_DATA);
    localparam logic [REG_AW-1:0] A_CFG  = REG_AW'(OFS_CFG);

    ctl_word_t wr_ctl;
    ctl_word_t ctl_view;
    logic      hit_ctrl;
    logic      hit_cfg;

    assign wr_ctl   = ctl_word_t'(bus_wdata);
    assign hit_ctrl = bus_sel && bus_we && (bus_addr == A_CTRL);
    assign hit_cfg  = bus_sel && bus_we && (bus_addr == A_CFG);

    // falling start bit, armed and powered in the same write
    assign start_req = hit_ctrl && ctl_q.rd_go && !wr_ctl.rd_go
                       && wr_ctl.rd_arm && !wr_ctl.pwr_down;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= CTL_RESET;
            enc_q    <= 1'b1;
            addr_lat <= '0;
        end else begin
            if (hit_ctrl) begin
                ctl_q <= ctl_sanitize(wr_ctl);
                if (ctl_q.addr_stb && !wr_ctl.addr_stb) begin
                    addr_lat <= wr_ctl.faddr;
                end
            end
            if (hit_cfg) begin
                enc_q <= bus_wdata[ENC_POS];
            end
        end
    end

    always_comb begin
        ctl_view         = ctl_q;
        ctl_view.rd_busy = rd_busy;
        ctl_view.wr_busy = 1'b0;
        bus_rdata        = '0;
        if (bus_sel && !bus_we) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = ctl_view;
                A_DATA:  bus_rdata = rd_word;
                A_CFG:   bus_rdata[ENC_POS] = enc_q;
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/fuse_rd_ctrl.sv
`timescale 1ns/1ps
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int WORD_BYTES   = 4,
    parameter int FETCH_CYCLES = 16,
    parameter int FUSE_BYTES   = 512,
    parameter int REG_AW       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    ctl_word_t          ctl_q;
    logic               enc_q;
    logic [FADDR_W-1:0] addr_lat;
    logic               start_req;
    logic               rd_busy;
    logic               fetch_launch;
    logic [DATA_W-1:0]  rd_word;
    logic [FADDR_W-1:0] fetch_addr;

    fuse_rd_regs #(
        .REG_AW (REG_AW)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_busy   (rd_busy),
        .rd_word   (rd_word),
        .ctl_q     (ctl_q),
        .enc_q     (enc_q),
        .addr_lat  (addr_lat),
        .start_req (start_req),
        .bus_rdata (bus_rdata)
    );

    fuse_rd_seq #(
        .WORD_BYTES   (WORD_BYTES),
        .FETCH_CYCLES (FETCH_CYCLES),
        .FUSE_BYTES   (FUSE_BYTES)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .addr_lat   (addr_lat),
        .busy       (rd_busy),
        .launch     (fetch_launch),
        .data_q     (rd_word),
        .fetch_addr (fetch_addr)
    );

endmodule

// File: rtl/fuse_rd_ctrl_chk.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_chk #(
    parameter int FETCH_CYCLES = 16,
    parameter int REG_AW       = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              busy,
    input logic              launch,
    input logic              pd_q,
    input logic [31:0]       data_q,
    input logic [10:0]       fetch_addr
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= busy ? run_q + 16'd1 : 16'd0;
    end

    // R4: a launch is visible as busy one cycle later
    a_r4_busy_after_launch: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);

    // R5: busy never outlives the fetch time
    a_r5_busy_bound: assert property (@(posedge clk) disable iff (rst)
        int'(run_q) <= FETCH_CYCLES);

    // R5: data word changes only where busy clears
    a_r5_data_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(data_q) |-> $fell(busy));

    // R6: powered down and idle stays idle
    a_r6_pd_blocks: assert property (@(posedge clk) disable iff (rst)
        (pd_q && !busy) |=> (!busy || !pd_q));

    // R7: fetch address held for the whole fetch
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(fetch_addr));

    // R11: program-path status always reads 0
    a_r11_wr_busy_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we && bus_addr == REG_AW'(4)) |-> !bus_rdata[14]);

endmodule

bind fuse_rd_ctrl fuse_rd_ctrl_chk #(
    .FETCH_CYCLES (FETCH_CYCLES),
    .REG_AW       (REG_AW)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .busy       (rd_busy),
    .launch     (fetch_launch),
    .pd_q       (ctl_q.pwr_down),
    .data_q     (rd_word),
    .fetch_addr (fetch_addr)
);

// File: tb/fuse_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module fuse_rd_ctrl_tb_top;

    localparam int FETCH = 16;
    localparam int NV    = 10;
    // {power-down, read-enable, address}
    localparam logic [12:0] VEC [NV] = '{
        {2'b01, 11'd0},   {2'b01, 11'd1},   {2'b01, 11'd5},
        {2'b01, 11'd127}, {2'b01, 11'd128}, {2'b11, 11'd9},
        {2'b00, 11'd10},  {2'b01, 11'd300}, {2'b01, 11'd511},
        {2'b01, 11'd2047}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [31:0] rd_a, rd_b;
    logic [31:0] exp4, exp1;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    fuse_rd_ctrl #(.WORD_BYTES(4), .FETCH_CYCLES(FETCH)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a));

    fuse_rd_ctrl #(.WORD_BYTES(1), .FETCH_CYCLES(FETCH)) dut_b_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b));

    function automatic logic [7:0] rb(input int a);
        int v;
        v = ((a % 256) * 13 + 7) % 256;
        if (a >= 256) v = v ^ 255;
        return 8'(v);
    endfunction

    function automatic logic [31:0] ref4(input int i);
        if (i >= 128) return 32'h0;
        return {rb(4*i+3), rb(4*i+2), rb(4*i+1), rb(4*i)};
    endfunction

    function automatic logic [31:0] ref1(input int i);
        if (i >= 512) return 32'h0;
        return {24'h0, rb(i)};
    endfunction

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // called just after a negedge; ends just after the next negedge
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        rd_a = rdata_a; rd_b = rdata_b;
        bus_sel = 1'b0;
    endtask

    task automatic poll_busy(output int n);
        n = 0;
        rd(5'h04);
        while (rd_a[26] && n < 1000) begin
            n++;
            @(negedge clk);
            rd(5'h04);
        end
    endtask

    task automatic full_read(input int a, input bit pd, input bit en);
        logic [31:0] base;
        base = (32'(pd) << 27) | (32'(en) << 24) | 32'(a);
        wr(5'h04, base);
        wr(5'h04, base | 32'h800);
        wr(5'h04, base);
        wr(5'h04, base | 32'h0200_0000);
        wr(5'h04, base);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        rd(5'h04); chk_eq("R1 ctrl reset", rd_a, 32'h0800_0000);
        rd(5'h10); chk_eq("R1 cfg reset", rd_a, 32'h0000_0400);
        rd(5'h08); chk_eq("R1 data reset", rd_a, 32'h0);
        @(negedge clk);

        // R2 storage
        wr(5'h04, 32'h08A5_3123);
        rd(5'h04); chk_eq("R2 ctrl readback", rd_a, 32'h08A5_3123);
        @(negedge clk);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h10); chk_eq("R2 cfg only bit 10", rd_a, 32'h0000_0400);
        @(negedge clk);
        wr(5'h10, 32'h0);
        rd(5'h10); chk_eq("R2 cfg cleared", rd_a, 32'h0);
        @(negedge clk);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C); chk_eq("R2 unmapped offset", rd_a, 32'h0);
        @(negedge clk);

        // R11 busy bits not writable
        wr(5'h04, 32'h0C00_4000);
        rd(5'h04); chk_eq("R11 busy bits ignored", rd_a, 32'h0800_0000);
        @(negedge clk);

        // vector table: R4 R5 R6 R8 R9 R10 R12
        exp4 = 32'h0; exp1 = 32'h0;
        for (int i = 0; i < NV; i++) begin
            full_read(int'(VEC[i][10:0]), VEC[i][12], VEC[i][11]);
            poll_busy(n);
            if (!VEC[i][12] && VEC[i][11]) begin
                exp4 = ref4(int'(VEC[i][10:0]));
                exp1 = ref1(int'(VEC[i][10:0]));
                chk_eq("R4 R5 busy cycles", 32'(n), 32'(FETCH));
            end else begin
                chk_eq("R6 start ignored busy", 32'(n), 32'h0);
            end
            rd(5'h08);
            chk_eq("R8 R10 R12 4-byte word", rd_a, exp4);
            chk_eq("R9 R10 R12 1-byte word", rd_b, exp1);
            @(negedge clk);
        end

        // R3 latch only on strobe fall
        full_read(9, 1'b0, 1'b1);
        poll_busy(n);
        @(negedge clk);
        wr(5'h04, 32'h0100_0802);
        wr(5'h04, 32'h0100_0002);
        rd(5'h08); chk_eq("R3 strobe alone no fetch", rd_a, ref4(9));
        @(negedge clk);
        wr(5'h04, 32'h0100_0004);
        wr(5'h04, 32'h0300_0004);
        wr(5'h04, 32'h0100_0004);
        poll_busy(n);
        chk_eq("R3 busy cycles", 32'(n), 32'(FETCH));
        rd(5'h08);
        chk_eq("R3 latched address 4-byte", rd_a, ref4(2));
        chk_eq("R3 latched address 1-byte", rd_b, ref1(2));
        @(negedge clk);

        // R11 data word not writable
        wr(5'h08, 32'hDEAD_BEEF);
        rd(5'h08); chk_eq("R11 data write ignored", rd_a, ref4(2));
        @(negedge clk);

        // R7 start during fetch ignored
        full_read(20, 1'b0, 1'b1);
        wr(5'h04, 32'h0100_081E);
        wr(5'h04, 32'h0100_001E);
        wr(5'h04, 32'h0300_001E);
        wr(5'h04, 32'h0100_001E);
        poll_busy(n);
        chk_eq("R7 original end time", 32'(n + 4), 32'(FETCH));
        rd(5'h08);
        chk_eq("R7 original address 4-byte", rd_a, ref4(20));
        chk_eq("R7 original address 1-byte", rd_b, ref1(20));
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule